// File: doc/BRIEF.md
# Acquire/Release Access Ordering Gate

This unit sits between a request source and a memory port. It decides, request by request, whether the next access may go out now under release-consistency rules. The source presents one access at a time, tagged as a plain load, a plain store, an acquire or a release. The gate forwards it to memory together with a transaction ID, or holds it with back-pressure. Memory later returns a completion that carries the ID. The completion frees that ID for reuse.

Stalls are asymmetric. Plain accesses that come after an acquire wait until that acquire has completed. A release waits until every plain access before it has completed. Synchronisation operations never overlap each other. Plain accesses overlap freely between synchronisation points. An acquire does not wait for earlier plain accesses, and accesses after a release do not wait for it. The request path holds no storage. A request is taken in the same cycle that memory accepts it.

Top module: `rc_issue_gate`

## Requirements
- R1: The access kind is a 2-bit code: 00 load, 01 store, 10 acquire, 11 release. `mem_valid` is raised only while `req_valid` is high. When it is raised, `mem_kind` and `mem_addr` equal `req_kind` and `req_addr`.
- R2: A load or store is not issued while an acquire is outstanding.
- R3: A release is not issued while any load or store is outstanding.
- R4: An acquire or release is not issued while another acquire or release is outstanding.
- R5: When R2, R3, R4 and R6 do not block a request, it is issued. In particular, loads and stores issue while other loads, stores or a release are outstanding. An acquire issues while loads and stores are outstanding.
- R6: At most 4 transactions are outstanding. With all 4 IDs in use, no request is issued.
- R7: An issued request takes the lowest-numbered free ID on `mem_id`. A completion for a busy ID frees it from the next cycle on. A completion for a free ID has no effect.
- R8: `ord_count` gives the number of outstanding loads and stores. `acq_pending` is high while an acquire is outstanding. After reset both are zero and nothing is outstanding.
- R9: `req_ready` is high exactly when `mem_valid` and `mem_ready` are both high. An access offered while `mem_ready` is low is neither taken nor recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Source offers an access |
| req_kind | input | 2 | Access kind code |
| req_addr | input | AW | Access address |
| req_ready | output | 1 | Access taken this cycle |
| mem_valid | output | 1 | Access presented to memory |
| mem_kind | output | 2 | Kind forwarded to memory |
| mem_addr | output | AW | Address forwarded to memory |
| mem_id | output | 2 | Transaction ID given to the access |
| mem_ready | input | 1 | Memory accepts the access |
| cpl_valid | input | 1 | Completion strobe |
| cpl_id | input | 2 | ID being completed |
| ord_count | output | 3 | Outstanding loads and stores |
| acq_pending | output | 1 | An acquire is outstanding |

## Verification
Completions return in any order and at random times. The hard case to reach from the ports is one where an acquire is outstanding while older plain accesses are still in flight and every ID is in use. It is also hard to reach a release that waits on a single late plain completion. Random stimulus weights loads and stores heavily and holds completions back with a low rate, so the ID pool often fills. A directed prefix builds each of these states on purpose, including a completion aimed at a free ID.

// File: rtl/rc_gate_pkg.sv
// Shared types for the ordering gate.
// Assumes the 2-bit kind encoding is fixed at the block boundary.
package rc_gate_pkg;
    typedef enum logic [1:0] {
        ACC_LOAD  = 2'b00,
        ACC_STORE = 2'b01,
        ACC_ACQ   = 2'b10,
        ACC_REL   = 2'b11
    } acc_kind_e;

    // Bit 1 of the code marks a synchronisation operation.
    function automatic logic kind_is_sync(input logic [1:0] k);
        return k[1];
    endfunction
endpackage

// File: rtl/rc_slot_table.sv
// Per-ID outstanding-transaction table.
// An entry becomes busy on allocation and clears on a matching completion.
// Assumes an allocation never targets a busy entry.
// A completion for a free entry is dropped.
module rc_slot_table #(
    parameter int SLOTS = 4,
    localparam int IDW = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_en,
    input  logic [IDW-1:0]   alloc_id,
    input  logic [1:0]       alloc_kind,
    input  logic             cpl_valid,
    input  logic [IDW-1:0]   cpl_id,
    output logic [SLOTS-1:0] busy,
    output logic [SLOTS-1:0] ord_busy,
    output logic [SLOTS-1:0] acq_busy,
    output logic [SLOTS-1:0] sync_busy
);
    import rc_gate_pkg::*;

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        logic [1:0] kind_q;

        // Hold the busy flag and kind of entry i.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                busy[i] <= 1'b0;
                kind_q  <= 2'b00;
            end else if (alloc_en && alloc_id == IDW'(i)) begin
                busy[i] <= 1'b1;
                kind_q  <= alloc_kind;
            end else if (cpl_valid && cpl_id == IDW'(i) && busy[i]) begin
                busy[i] <= 1'b0;
            end
        end

        // Classify the entry for the ordering rules.
        always_comb begin
            ord_busy[i]  = busy[i] && !kind_is_sync(kind_q);
            sync_busy[i] = busy[i] &&  kind_is_sync(kind_q);
            acq_busy[i]  = busy[i] && (kind_q == ACC_ACQ);
        end

        // R6: an ID is never handed out twice.
        a_r6_alloc_free: assert property (@(posedge clk) disable iff (!rst_n)
            alloc_en && alloc_id == IDW'(i) |-> !busy[i]);
        // R7: an allocated entry is busy in the following cycle.
        a_r7_busy_after_alloc: assert property (@(posedge clk) disable iff (!rst_n)
            alloc_en && alloc_id == IDW'(i) |=> busy[i]);
    end
endmodule

// File: rtl/rc_id_picker.sv
// Chooses the lowest-numbered free transaction ID.
// Purely combinational. Assumes `busy` comes from registered state.
module rc_id_picker #(
    parameter int SLOTS = 4,
    localparam int IDW = $clog2(SLOTS)
) (
    input  logic [SLOTS-1:0] busy,
    output logic             any_free,
    output logic [IDW-1:0]   free_id
);
    // Scan from the top so the lowest free index wins.
    always_comb begin
        any_free = 1'b0;
        free_id  = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                any_free = 1'b1;
                free_id  = IDW'(i);
            end
        end
    end
endmodule

// File: rtl/rc_order_rules.sv
// Release-consistency issue rules for the request at the head.
// Assumes the outstanding summaries reflect only completed-before-now state.
module rc_order_rules (
    input  logic [1:0] kind,
    input  logic       any_free,
    input  logic       ord_out,
    input  logic       acq_out,
    input  logic       sync_out,
    output logic       permit
);
    import rc_gate_pkg::*;

    // Decide whether the head access may leave this cycle.
    always_comb begin
        unique case (kind)
            ACC_LOAD, ACC_STORE: permit = !acq_out;
            ACC_ACQ:             permit = !sync_out;
            ACC_REL:             permit = !sync_out && !ord_out;
            default:             permit = 1'b0;
        endcase
        permit = permit && any_free;
    end
endmodule

// File: rtl/rc_issue_gate.sv
// Ordering gate in front of a memory port.
// Forwards tagged accesses with an ID when release-consistency rules allow it.
// Assumes memory completes each ID at most once per issue.
module rc_issue_gate #(
    parameter int SLOTS = 4,
    parameter int AW    = 32,
    localparam int IDW  = $clog2(SLOTS),
    localparam int CNTW = $clog2(SLOTS + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [1:0]      req_kind,
    input  logic [AW-1:0]   req_addr,
    output logic            req_ready,
    output logic            mem_valid,
    output logic [1:0]      mem_kind,
    output logic [AW-1:0]   mem_addr,
    output logic [IDW-1:0]  mem_id,
    input  logic            mem_ready,
    input  logic            cpl_valid,
    input  logic [IDW-1:0]  cpl_id,
    output logic [CNTW-1:0] ord_count,
    output logic            acq_pending
);
    import rc_gate_pkg::*;

    logic [SLOTS-1:0] busy, ord_busy, acq_busy, sync_busy;
    logic             any_free, permit, issue;
    logic [IDW-1:0]   free_id;

    rc_slot_table #(.SLOTS(SLOTS)) u_table (
        .clk(clk), .rst_n(rst_n),
        .alloc_en(issue), .alloc_id(free_id), .alloc_kind(req_kind),
        .cpl_valid(cpl_valid), .cpl_id(cpl_id),
        .busy(busy), .ord_busy(ord_busy), .acq_busy(acq_busy), .sync_busy(sync_busy)
    );

    rc_id_picker #(.SLOTS(SLOTS)) u_pick (
        .busy(busy), .any_free(any_free), .free_id(free_id)
    );

    rc_order_rules u_rules (
        .kind(req_kind), .any_free(any_free),
        .ord_out(|ord_busy), .acq_out(|acq_busy), .sync_out(|sync_busy),
        .permit(permit)
    );

    // Drive the memory side straight from the head request.
    always_comb begin
        mem_valid = req_valid && permit;
        mem_kind  = req_kind;
        mem_addr  = req_addr;
        mem_id    = free_id;
        issue     = mem_valid && mem_ready;
        req_ready = issue;
    end

    // Summarise outstanding state for the status outputs.
    always_comb begin
        ord_count = '0;
        for (int i = 0; i < SLOTS; i++) ord_count = ord_count + CNTW'(ord_busy[i]);
        acq_pending = |acq_busy;
    end

    // R2: a plain access never leaves while an acquire is open.
    a_r2_no_ord_after_acq: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !kind_is_sync(mem_kind) |-> !acq_pending);
    // R3: a release never leaves with plain accesses in flight.
    a_r3_rel_after_ord: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && mem_kind == ACC_REL |-> ord_count == '0);
    // R6: the count stays within the ID pool.
    a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        ord_count <= CNTW'(SLOTS));
    // R1: memory side is only active with a request present.
    a_r1_valid_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> req_valid);
    // R9: taking a request requires memory acceptance.
    a_r9_ready_needs_mem: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> mem_ready && mem_valid);
    // R8: an acquire accepted shows up as pending next cycle.
    a_r8_acq_visible: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready && req_kind == ACC_ACQ |=> acq_pending);
endmodule

// File: tb/rc_issue_gate_bench.sv
module rc_issue_gate_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'b00;
    logic [31:0] req_addr = '0;
    logic        req_ready, mem_valid, mem_ready = 1'b0;
    logic [1:0]  mem_kind, mem_id;
    logic [31:0] mem_addr;
    logic        cpl_valid = 1'b0;
    logic [1:0]  cpl_id = 2'b00;
    logic [2:0]  ord_count;
    logic        acq_pending;

    int checks = 0, errors = 0;
    logic       m_busy [4];
    logic [1:0] m_kind [4];

    rc_issue_gate u_rc_issue_gate (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_ready(req_ready), .mem_valid(mem_valid),
        .mem_kind(mem_kind), .mem_addr(mem_addr), .mem_id(mem_id),
        .mem_ready(mem_ready), .cpl_valid(cpl_valid), .cpl_id(cpl_id),
        .ord_count(ord_count), .acq_pending(acq_pending)
    );

    always #10 clk = ~clk;

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int m_ord();
        int n = 0;
        for (int i = 0; i < 4; i++) if (m_busy[i] && !m_kind[i][1]) n++;
        return n;
    endfunction

    function automatic logic m_acq();
        for (int i = 0; i < 4; i++) if (m_busy[i] && m_kind[i] == 2'b10) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic m_sync();
        for (int i = 0; i < 4; i++) if (m_busy[i] && m_kind[i][1]) return 1'b1;
        return 1'b0;
    endfunction

    function automatic int m_low();
        for (int i = 0; i < 4; i++) if (!m_busy[i]) return i;
        return -1;
    endfunction

    // Which requirement decides the expected outcome.
    function automatic string why(input logic v, input logic [1:0] k);
        if (!v) return "R1";
        if (m_low() < 0) return "R6";
        if (!k[1] && m_acq()) return "R2";
        if (k == 2'b11 && m_ord() != 0) return "R3";
        if (k[1] && m_sync()) return "R4";
        return "R5";
    endfunction

    function automatic logic m_permit(input logic [1:0] k);
        if (m_low() < 0) return 1'b0;
        if (!k[1]) return !m_acq();
        if (k == 2'b10) return !m_sync();
        return !m_sync() && m_ord() == 0;
    endfunction

    task automatic step(input logic v, input logic [1:0] k, input logic [31:0] a,
                        input logic mr, input logic cv, input logic [1:0] cid);
        logic exp_mv;
        logic hit;
        int   low;
        @(negedge clk);
        req_valid = v; req_kind = k; req_addr = a; mem_ready = mr;
        cpl_valid = cv; cpl_id = cid;
        #2;
        exp_mv = v && m_permit(k);
        low = m_low();
        chk(mem_valid == exp_mv, why(v, k), int'(mem_valid), int'(exp_mv));
        chk(req_ready == (exp_mv && mr), "R9", int'(req_ready), int'(exp_mv && mr));
        if (exp_mv) begin
            chk(int'(mem_id) == low, "R7", int'(mem_id), low);
            chk(mem_kind == k && mem_addr == a, "R1", int'(mem_addr), int'(a));
        end
        chk(int'(ord_count) == m_ord(), "R8", int'(ord_count), m_ord());
        chk(acq_pending == m_acq(), "R8", int'(acq_pending), int'(m_acq()));
        hit = cv && m_busy[cid];
        if (hit) m_busy[cid] = 1'b0;
        if (exp_mv && mr) begin
            m_busy[low] = 1'b1;
            m_kind[low] = k;
        end
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) begin m_busy[i] = 1'b0; m_kind[i] = 2'b00; end
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R8: reset state
        step(0, 2'b00, 0, 1, 0, 0);
        // R6: fill the pool with loads and stores, then a fifth is held
        step(1, 2'b00, 32'h10, 1, 0, 0);
        step(1, 2'b01, 32'h14, 1, 0, 0);
        step(1, 2'b00, 32'h18, 1, 0, 0);
        step(1, 2'b01, 32'h1c, 1, 0, 0);
        step(1, 2'b00, 32'h20, 1, 0, 0);
        // R7: a completion frees ID 1, which is then reused
        step(0, 2'b00, 0, 1, 1, 2'd1);
        step(1, 2'b00, 32'h24, 1, 0, 0);
        // R5: an acquire issues over open loads
        step(0, 2'b00, 0, 1, 1, 2'd0);
        step(1, 2'b10, 32'h80, 1, 0, 0);
        // R2: a load after the acquire is held; R4: release held
        step(1, 2'b00, 32'h28, 1, 0, 0);
        step(1, 2'b11, 32'h84, 1, 1, 2'd0);
        // R3: release waits for the last plain access
        step(1, 2'b11, 32'h84, 1, 1, 2'd1);
        step(1, 2'b11, 32'h84, 1, 1, 2'd2);
        step(1, 2'b11, 32'h84, 1, 1, 2'd3);
        step(1, 2'b11, 32'h84, 1, 0, 0);
        // R5: a store after an open release; R4: acquire held
        step(1, 2'b01, 32'h30, 1, 0, 0);
        step(1, 2'b10, 32'h88, 1, 0, 0);
        // R9: memory not ready, nothing recorded
        step(1, 2'b00, 32'h34, 0, 0, 0);
        step(0, 2'b00, 0, 1, 0, 0);
        // R7: completion of a free ID is ignored
        step(0, 2'b00, 0, 1, 1, 2'd3);
        step(0, 2'b00, 0, 1, 0, 0);
        // Random mix
        for (int n = 0; n < 4000; n++) begin
            int r = $urandom_range(0, 9);
            logic [1:0] k = (r < 7) ? 2'($urandom_range(0, 1)) : ((r == 7) ? 2'b10 : 2'b11);
            step($urandom_range(0, 4) != 0, k, $urandom,
                 $urandom_range(0, 5) != 0, $urandom_range(0, 2) == 0,
                 2'($urandom_range(0, 3)));
        end
        // Drain all IDs
        for (int i = 0; i < 4; i++) step(0, 2'b00, 0, 1, 1, 2'(i));
        step(0, 2'b00, 0, 1, 0, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule